// File: doc/BRIEF.md
# Bit-Field and Bit-Test Extension Execute Unit

This block executes a group of extension instructions for a 64-bit core. It takes one instruction word per cycle, together with the values of its two source registers and the program counter of the instruction. It returns one of four results: a register write (index, enable, data), a resolved bit-test branch (taken flag and target), a reserved-instruction exception, or a flag saying the word is not one of its instructions. The register file, the multiplier and pipeline control stay outside. A base decoder uses the flag to take over any word this unit does not claim.

The unit covers byte-wide addition, population count over 32 or 64 bits, set-on-equal and set-on-not-equal against a register or a 10-bit signed immediate, signed bit-field extraction, zero-filled bit-field insertion, and branch on a single bit being set or clear. All results are registered, so they appear one clock after the instruction is presented.

Top module: `bx_exec_unit`

## Requirements
- R1: Every output is registered. `out_valid` follows `in_valid` one cycle later. When `in_valid` was low, `wr_en`, `br_valid`, `br_taken`, `ri_exc` and `not_decoded` are low, and `wr_idx`, `wr_data` and `br_target` are zero. At most one of `wr_en`, `br_valid`, `ri_exc` and `not_decoded` is high in any cycle. After a synchronous active-high reset all outputs are zero.
- R2: Byte add is major opcode 011100 (bits 31:26) with bits 10:0 equal to 0x028. It writes `(src_a + src_b) & 0xFF`, zero-extended to 64 bits, to the register named by bits 15:11.
- R3: Population count is major opcode 011100 with bits 5:1 = 10110, bits 20:16 = 0 and bits 10:6 = 0. It writes the number of one bits of `src_a` to the register named by bits 15:11. Bit 0 = 1 counts all 64 bits; bit 0 = 0 counts bits 31:0 only.
- R4: Register compare is major opcode 011100 with bits 5:1 = 10101 and bits 10:6 = 0. It writes 1 or 0 to the register named by bits 15:11. Bit 0 = 0 tests `src_a == src_b`; bit 0 = 1 tests `src_a != src_b`.
- R5: Immediate compare is major opcode 011100 with bits 5:1 = 10111. It compares `src_a` with bits 15:6, taken as a signed 10-bit value and sign-extended to 64 bits. It writes 1 or 0 to the register named by bits 20:16. Bit 0 selects not-equal, as in R4.
- R6: Field extract is major opcode 011100 with bits 5:1 = 11101. The position P is {bit 0, bits 10:6} and the length L is bits 15:11 plus 1. The result bit i (i < L) is `src_a[P+i]`, and is 0 when P+i > 63. The result is sign-extended from its bit L-1. It is written to the register named by bits 20:16.
- R7: Field insert is major opcode 011100 with bits 5:1 = 11001, using the same P and L as R6. The low L bits of `src_a` are placed at bits P and up; bits past 63 are dropped and all other bits are zero. The result is written to the register named by bits 20:16.
- R8: A bit-test branch has bits 31:30 = 11, bit 27 = 1 and bit 26 = 0. The bit index is {bit 28, bits 20:16}. Bit 29 = 1 branches when that bit of `src_a` is 1; bit 29 = 0 branches when it is 0. The unit reports `br_valid` and sets `br_taken` accordingly.
- R9: The branch target is `pc + 4 + 4 * offset`, where offset is bits 15:0 taken as a signed value. The target is reported whether or not the branch is taken.
- R10: A bit-test branch presented with `in_slot` high raises `ri_exc` and reports no branch.
- R11: An extension operation whose destination index is 0 leaves `wr_en` low and `wr_idx` and `wr_data` zero.
- R12: A valid word that matches none of R2 to R8 raises `not_decoded`, with nothing written and no branch reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_slot | input | 1 | Instruction sits in a delay or forbidden slot |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | Value of the register in bits 25:21 |
| src_b | input | 64 | Value of the register in bits 20:16 |
| pc | input | 64 | Address of the instruction |
| out_valid | output | 1 | Results below belong to the instruction of the previous cycle |
| wr_en | output | 1 | Register write request |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 64 | Value to write |
| br_valid | output | 1 | A bit-test branch was resolved |
| br_taken | output | 1 | The branch is taken |
| br_target | output | 64 | Branch destination address |
| ri_exc | output | 1 | Reserved-instruction exception |
| not_decoded | output | 1 | Word not claimed by this unit |

## Verification
Every result of this unit, whether a register write, a branch resolution, the exception or the not-decoded flag, is due exactly one clock after the instruction is presented. The bench drives each instruction on a falling edge. On the next falling edge it compares the whole output set against a behavioural model evaluated on that same instruction, so the comparison always lands in the cycle after the rising edge that captured the result. Idle cycles are interleaved with instructions, so the cleared outputs of R1 are checked in that same one-cycle slot.

// File: rtl/bx_pkg.sv
`timescale 1ns/1ps
package bx_pkg;
  localparam int unsigned BX_XLEN = 64;
  localparam int unsigned BX_POSW = $clog2(BX_XLEN);
  localparam int unsigned BX_LENW = 5;
  localparam int unsigned BX_IMMW = 10;
  localparam int unsigned BX_OFFW = 16;
  localparam int unsigned BX_REGW = 5;

  typedef enum logic [2:0] {
    OP_NONE, OP_BADD, OP_POP, OP_SEQ, OP_SEQI, OP_EXTS, OP_CINS, OP_BBIT
  } bx_op_e;

  typedef struct packed {
    bx_op_e               op;
    logic                 flag;   // not-equal / full width / branch-if-set
    logic [BX_REGW-1:0]   dst;
    logic [BX_POSW-1:0]   pos;
    logic [BX_LENW-1:0]   lenm1;
    logic [BX_IMMW-1:0]   imm;
    logic [BX_OFFW-1:0]   off;
  } bx_dec_t;
endpackage

// File: rtl/bx_decode.sv
`timescale 1ns/1ps
module bx_decode
  import bx_pkg::*;
(
  input  logic [31:0] instr,
  output bx_dec_t     dec
);
  localparam logic [5:0] MAJ_EXT = 6'b011100;

  logic [5:0] maj;
  logic [5:0] fn;
  logic       sa_zero;
  logic       unused_rs;

  assign maj       = instr[31:26];
  assign fn        = instr[5:0];
  assign sa_zero   = (instr[10:6] == 5'd0);
  assign unused_rs = ^instr[25:21];

  always_comb begin
    dec       = '0;
    dec.op    = OP_NONE;
    dec.flag  = fn[0];
    dec.pos   = {instr[0], instr[10:6]};
    dec.lenm1 = instr[15:11];
    dec.imm   = instr[15:6];
    dec.off   = instr[15:0];
    dec.dst   = instr[15:11];
    if (maj[5:4] == 2'b11 && maj[1:0] == 2'b10) begin
      dec.op   = OP_BBIT;
      dec.flag = instr[29];
      dec.pos  = {instr[28], instr[20:16]};
      dec.dst  = '0;
    end else if (maj == MAJ_EXT) begin
      unique case (fn[5:1])
        5'b10100: if (!fn[0] && sa_zero) dec.op = OP_BADD;
        5'b10101: if (sa_zero) dec.op = OP_SEQ;
        5'b10110: if (sa_zero && instr[20:16] == 5'd0) dec.op = OP_POP;
        5'b10111: begin dec.op = OP_SEQI; dec.dst = instr[20:16]; end
        5'b11001: begin dec.op = OP_CINS; dec.dst = instr[20:16]; end
        5'b11101: begin dec.op = OP_EXTS; dec.dst = instr[20:16]; end
        default:  dec.op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bx_alu.sv
`timescale 1ns/1ps
module bx_alu
  import bx_pkg::*;
#(
  parameter int unsigned XLEN = BX_XLEN
) (
  input  bx_op_e              op,
  input  logic                flag,
  input  logic [BX_POSW-1:0]  pos,
  input  logic [BX_LENW-1:0]  lenm1,
  input  logic [BX_IMMW-1:0]  imm,
  input  logic [XLEN-1:0]     a,
  input  logic [XLEN-1:0]     b,
  output logic [XLEN-1:0]     res
);
  localparam int unsigned CNTW = $clog2(XLEN) + 1;
  localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};

  logic [CNTW-1:0] cnt;
  logic [XLEN-1:0] mask, field, ext_res, ins_res, imm_x;
  logic [XLEN-1:0] sum;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < int'(XLEN); i++) begin
      if (flag || i < int'(XLEN / 2)) cnt = cnt + CNTW'(a[i]);
    end
  end

  assign mask    = ONES >> ((XLEN - 1) - int'(lenm1));
  assign field   = (a >> pos) & mask;
  assign ext_res = field[lenm1] ? (field | ~mask) : field;
  assign ins_res = (a & mask) << pos;
  assign imm_x   = {{(XLEN-BX_IMMW){imm[BX_IMMW-1]}}, imm};
  assign sum     = a + b;

  always_comb begin
    res = '0;
    unique case (op)
      OP_BADD: res = {{(XLEN-8){1'b0}}, sum[7:0]};
      OP_POP:  res = {{(XLEN-CNTW){1'b0}}, cnt};
      OP_SEQ:  res = {{(XLEN-1){1'b0}}, (a == b) ^ flag};
      OP_SEQI: res = {{(XLEN-1){1'b0}}, (a == imm_x) ^ flag};
      OP_EXTS: res = ext_res;
      OP_CINS: res = ins_res;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/bx_branch.sv
`timescale 1ns/1ps
module bx_branch
  import bx_pkg::*;
#(
  parameter int unsigned XLEN = BX_XLEN
) (
  input  logic                flag,
  input  logic [BX_POSW-1:0]  pos,
  input  logic [BX_OFFW-1:0]  off,
  input  logic [XLEN-1:0]     a,
  input  logic [XLEN-1:0]     pc,
  output logic                taken,
  output logic [XLEN-1:0]     target
);
  logic [XLEN-1:0] disp;

  assign taken  = flag ? a[pos] : ~a[pos];
  assign disp   = {{(XLEN-BX_OFFW-2){off[BX_OFFW-1]}}, off, 2'b00};
  assign target = pc + XLEN'(4) + disp;
endmodule

// File: rtl/bx_exec_unit.sv
`timescale 1ns/1ps
module bx_exec_unit
  import bx_pkg::*;
#(
  parameter int unsigned XLEN = BX_XLEN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_slot,
  input  logic [31:0]        instr,
  input  logic [XLEN-1:0]    src_a,
  input  logic [XLEN-1:0]    src_b,
  input  logic [XLEN-1:0]    pc,
  output logic               out_valid,
  output logic               wr_en,
  output logic [BX_REGW-1:0] wr_idx,
  output logic [XLEN-1:0]    wr_data,
  output logic               br_valid,
  output logic               br_taken,
  output logic [XLEN-1:0]    br_target,
  output logic               ri_exc,
  output logic               not_decoded
);
  bx_dec_t         dec;
  logic [XLEN-1:0] alu_res, tgt;
  logic            tk;
  logic            is_br, do_wr, do_br;

  bx_decode u_dec (.instr(instr), .dec(dec));

  bx_alu #(.XLEN(XLEN)) u_alu (
    .op(dec.op), .flag(dec.flag), .pos(dec.pos), .lenm1(dec.lenm1),
    .imm(dec.imm), .a(src_a), .b(src_b), .res(alu_res)
  );

  bx_branch #(.XLEN(XLEN)) u_br (
    .flag(dec.flag), .pos(dec.pos), .off(dec.off), .a(src_a), .pc(pc),
    .taken(tk), .target(tgt)
  );

  assign is_br = in_valid && dec.op == OP_BBIT;
  assign do_wr = in_valid && dec.op != OP_NONE && dec.op != OP_BBIT && dec.dst != '0;
  assign do_br = is_br && !in_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      wr_en       <= 1'b0;
      wr_idx      <= '0;
      wr_data     <= '0;
      br_valid    <= 1'b0;
      br_taken    <= 1'b0;
      br_target   <= '0;
      ri_exc      <= 1'b0;
      not_decoded <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      wr_en       <= do_wr;
      wr_idx      <= do_wr ? dec.dst : '0;
      wr_data     <= do_wr ? alu_res : '0;
      br_valid    <= do_br;
      br_taken    <= do_br && tk;
      br_target   <= do_br ? tgt : '0;
      ri_exc      <= is_br && in_slot;
      not_decoded <= in_valid && dec.op == OP_NONE;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(wr_en || br_valid || ri_exc || not_decoded)); // R1
  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en, br_valid, ri_exc, not_decoded})); // R1
  AST_BYTE_WIDE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'b011100 && instr[10:0] == 11'h028)
      |=> wr_data[XLEN-1:8] == '0); // R2
  AST_SLOT_TRAPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_slot && instr[31:30] == 2'b11 && instr[27:26] == 2'b10)
      |=> (ri_exc && !br_valid)); // R10
  AST_NO_ZERO_DEST: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_idx != '0); // R11
  AST_UNCLAIMED_SILENT: assert property (@(posedge clk) disable iff (rst)
    not_decoded |-> (!wr_en && !br_taken && br_target == '0)); // R12
endmodule

// File: tb/bx_exec_unit_tb.sv
`timescale 1ns/1ps
module bx_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_slot = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_a = '0, src_b = '0, pc = '0;
  logic        out_valid, wr_en, br_valid, br_taken, ri_exc, not_decoded;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data, br_target;

  always #4 clk = ~clk;

  bx_exec_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_slot(in_slot), .instr(instr),
    .src_a(src_a), .src_b(src_b), .pc(pc), .out_valid(out_valid), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .br_valid(br_valid), .br_taken(br_taken),
    .br_target(br_target), .ri_exc(ri_exc), .not_decoded(not_decoded)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic        e_ov, e_wen, e_brv, e_tk, e_ri, e_nd;
  logic [4:0]  e_idx;
  logic [63:0] e_dat, e_tgt;
  string       e_tag = "R1";

  function automatic logic [31:0] enc_r(input int rs, rt, rd, sa, fn);
    return {6'b011100, 5'(rs), 5'(rt), 5'(rd), 5'(sa), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_b(input bit set, input int idx, rs, off);
    logic [5:0] ix = 6'(idx);
    return {2'b11, set, ix[5], 2'b10, 5'(rs), ix[4:0], 16'(off)};
  endfunction

  task automatic model(input bit v, slot, input logic [31:0] w,
                       input logic [63:0] a, b, p);
    bit known = 0;
    int dst = 0;
    logic [63:0] r = '0;
    int ps, ln, n;
    longint im;
    e_ov = v; e_wen = 0; e_idx = 0; e_dat = 0; e_brv = 0; e_tk = 0; e_tgt = 0;
    e_ri = 0; e_nd = 0; e_tag = "R1";
    if (!v) return;
    ps = int'(w[0]) * 32 + int'(w[10:6]);
    ln = int'(w[15:11]) + 1;
    if (w[31] && w[30] && w[27] && !w[26]) begin
      if (slot) begin e_ri = 1; e_tag = "R10"; return; end
      n = int'(w[28]) * 32 + int'(w[20:16]);
      e_brv = 1;
      e_tk  = w[29] ? a[n] : !a[n];
      e_tgt = p + 64'd4 + 64'(longint'($signed(w[15:0])) * 4);
      e_tag = "R8/R9";
      return;
    end
    if (w[31:26] == 6'b011100) begin
      case (w[5:0])
        6'h28: if (w[10:6] == 0) begin
                 known = 1; dst = int'(w[15:11]); r = (a + b) % 256; e_tag = "R2";
               end
        6'h2a, 6'h2b: if (w[10:6] == 0) begin
                 known = 1; dst = int'(w[15:11]);
                 r = ((a == b) != w[0]) ? 64'd1 : 64'd0; e_tag = "R4";
               end
        6'h2c, 6'h2d: if (w[10:6] == 0 && w[20:16] == 0) begin
                 known = 1; dst = int'(w[15:11]); n = w[0] ? 64 : 32;
                 for (int i = 0; i < n; i++) r = r + 64'(a[i]);
                 e_tag = "R3";
               end
        6'h2e, 6'h2f: begin
                 known = 1; dst = int'(w[20:16]);
                 im = longint'($signed(w[15:6]));
                 r = ((a == 64'(im)) != w[0]) ? 64'd1 : 64'd0; e_tag = "R5";
               end
        6'h32, 6'h33: begin
                 known = 1; dst = int'(w[20:16]);
                 for (int i = 0; i < ln; i++) if (ps + i < 64) r[ps+i] = a[i];
                 e_tag = "R7";
               end
        6'h3a, 6'h3b: begin
                 known = 1; dst = int'(w[20:16]);
                 for (int i = 0; i < ln; i++) r[i] = (ps + i < 64) ? a[ps+i] : 1'b0;
                 for (int i = ln; i < 64; i++) r[i] = r[ln-1];
                 e_tag = "R6";
               end
        default: known = 0;
      endcase
    end
    if (!known) begin e_nd = 1; e_tag = "R12"; return; end
    if (dst == 0) begin e_tag = "R11"; return; end
    e_wen = 1; e_idx = 5'(dst); e_dat = r;
  endtask

  task automatic check();
    compared++;
    if ({out_valid, wr_en, wr_idx, wr_data, br_valid, br_taken, br_target, ri_exc, not_decoded} !==
        {e_ov, e_wen, e_idx, e_dat, e_brv, e_tk, e_tgt, e_ri, e_nd}) begin
      mismatched++;
      $display("FAIL %s: actual ov=%b wen=%b idx=%0d dat=%h brv=%b tk=%b tgt=%h ri=%b nd=%b expected ov=%b wen=%b idx=%0d dat=%h brv=%b tk=%b tgt=%h ri=%b nd=%b",
               e_tag, out_valid, wr_en, wr_idx, wr_data, br_valid, br_taken, br_target, ri_exc, not_decoded,
               e_ov, e_wen, e_idx, e_dat, e_brv, e_tk, e_tgt, e_ri, e_nd);
    end
  endtask

  // Drive on a falling edge; the registered result is compared one clock later.
  task automatic step(input bit v, slot, input logic [31:0] w, input logic [63:0] a, b, p);
    @(negedge clk);
    check();
    in_valid = v; in_slot = slot; instr = w; src_a = a; src_b = b; pc = p;
    model(v, slot, w, a, b, p);
  endtask

  function automatic logic [31:0] rand_word();
    int k = int'($urandom_range(0, 8));
    int f = int'($urandom_range(0, 1));
    int rs = int'($urandom_range(0, 31)), rt = int'($urandom_range(0, 31));
    int rd = int'($urandom_range(0, 31)), sa = int'($urandom_range(0, 31));
    case (k)
      0: return enc_r(rs, rt, rd, ($urandom_range(0, 3) == 0) ? sa : 0, 6'h28 | f);
      1: return enc_r(rs, ($urandom_range(0, 3) == 0) ? rt : 0, rd, 0, 6'h2c | f);
      2: return enc_r(rs, rt, rd, 0, 6'h2a | f);
      3: return enc_r(rs, rt, rd, sa, 6'h2e | f);
      4: return enc_r(rs, rt, rd, sa, 6'h32 | f);
      5: return enc_r(rs, rt, rd, sa, 6'h3a | f);
      6: return enc_b(1'(f), int'($urandom_range(0, 63)), rs, int'($urandom_range(0, 65535)));
      default: return $urandom();
    endcase
  endfunction

  initial begin
    logic [63:0] ra, rb;
    model(0, 0, '0, '0, '0, '0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, then an idle cycle
    step(0, 0, 32'hFFFF_FFFF, '1, '1, '1);
    // R2: byte add wraps at 8 bits
    step(1, 0, enc_r(1, 2, 3, 0, 6'h28), 64'h0000_0000_0000_00FF, 64'h2, 0);
    step(1, 0, enc_r(1, 2, 3, 0, 6'h28), 64'hFFFF_FFFF_FFFF_FF80, 64'h7F, 0);
    // R3: full and half-width counts; nonzero rt field is not claimed (R12)
    step(1, 0, enc_r(1, 0, 4, 0, 6'h2d), '1, 0, 0);
    step(1, 0, enc_r(1, 0, 4, 0, 6'h2c), '1, 0, 0);
    step(1, 0, enc_r(1, 7, 4, 0, 6'h2c), '1, 0, 0);
    // R4: equal and not-equal
    step(1, 0, enc_r(1, 2, 5, 0, 6'h2a), 64'h1234, 64'h1234, 0);
    step(1, 0, enc_r(1, 2, 5, 0, 6'h2b), 64'h1234, 64'h1234, 0);
    // R5: immediate -1 and +511
    step(1, 0, enc_r(1, 6, 10'h3FF >> 5, 10'h3FF & 31, 6'h2e), '1, 0, 0);
    step(1, 0, enc_r(1, 6, 10'h1FF >> 5, 10'h1FF & 31, 6'h2f), 64'd511, 0, 0);
    // R6: extract crossing bit 63, from bit 32, and full 32-bit at 0
    step(1, 0, enc_r(1, 7, 7, 28, 6'h3b), 64'hF000_0000_0000_0000, 0, 0);
    step(1, 0, enc_r(1, 7, 15, 0, 6'h3b), 64'h0000_8000_0000_0000, 0, 0);
    step(1, 0, enc_r(1, 7, 31, 0, 6'h3a), 64'h0000_0000_8000_0001, 0, 0);
    // R7: insert at top bit drops overflow
    step(1, 0, enc_r(1, 8, 1, 31, 6'h33), 64'h3, 0, 0);
    // R8/R9: bit index with high bit, backward offset
    step(1, 0, enc_b(1, 40, 1, 16'hFFFE), 64'h0000_0100_0000_0000, 0, 64'h1000);
    step(1, 0, enc_b(0, 40, 1, 16'h0010), 64'h0000_0100_0000_0000, 0, 64'h1000);
    // R10: branch in slot
    step(1, 1, enc_b(1, 3, 1, 16'h0004), 64'h8, 0, 64'h2000);
    // R11: destination 0
    step(1, 0, enc_r(1, 0, 0, 0, 6'h2d), '1, 0, 0);
    // R12: unknown word
    step(1, 0, 32'h0000_0000, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      ra = {$urandom(), $urandom()};
      rb = ($urandom_range(0, 3) == 0) ? ra : {$urandom(), $urandom()};
      if ($urandom_range(0, 7) == 0) ra = 64'(longint'($signed(10'($urandom()))));
      step($urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0, rand_word(), ra, rb,
           {$urandom(), $urandom()});
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R1: watchdog expired, actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule